// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block produces a single pulse-width-modulated output for dimming a display backlight. Each period is 256 steps long. One step lasts 2^N ticks of the selected counting clock, where N is a 3-bit prescale setting. An 8-bit threshold sets how many steps of each period the output is at its active level. A polarity bit picks whether the active level is high or low. The counting source is either a slow tick strobe or every cycle of the system clock, chosen by an input pin. All logic runs on the system clock, and the slow source enters as a one-cycle tick pulse.

Software writes a 16-bit settings word. It starts the generator with a one-cycle start strobe and stops it with a separate one-cycle stop strobe. It then polls a running flag until the flag matches its request. New settings are held in a shadow register and only reach the output stage at a period boundary. Stopping also waits for the current period to end, so the waveform never changes partway through a period. While stopped, the step counter is held at zero and the output stays at its inactive level.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the running flag is 0, the output is low, and the active settings are threshold 0, polarity 1 (active-high) and prescale 0.
- R2: With the system clock selected, one output period lasts 256 × 2^N clock cycles. N is the prescale field, settings-word bits 2:0.
- R3: A prescale field of 7 acts exactly like 6, giving a period of 16384 counting ticks.
- R4: The output is at its active level during the first T steps of each period and inactive for the rest. T is the threshold field, settings-word bits 15:8. With T = 0 the output never reaches the active level.
- R5: With T = 255 the output is inactive for exactly one step per period, so the output is never active for a whole period.
- R6: Settings-word bit 4 set to 1 makes the active level high. Set to 0, it makes the active level low and the inactive level high.
- R7: With clk_sel_i = 1 every clock cycle is a counting tick. With clk_sel_i = 0 only cycles with slow_tick_i = 1 count, and the counter holds still between slow ticks.
- R8: A settings write while running does not change the threshold, polarity or prescale in use until the current period ends. The next period uses the new values.
- R9: A start strobe is captured on the next clock edge. The running flag then rises on the first later clock edge that carries a counting tick.
- R10: After a stop strobe, the running flag stays 1 until the current period completes. It falls on the edge that ends the period.
- R11: While stopped, the counter is held at zero, and the output sits at the inactive level set by the most recently written polarity. That setting takes effect two clock edges after the write.
- R12: A start strobe and a stop strobe in the same cycle act as a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_sel_i | input | 1 | Counting source: 1 = every system clock cycle, 0 = slow tick pulses |
| slow_tick_i | input | 1 | One-cycle pulse marking each slow-clock tick |
| cfg_we_i | input | 1 | Write strobe for the settings word |
| cfg_wdata_i | input | 16 | Settings word: threshold 15:8, polarity 4, prescale 2:0 |
| start_i | input | 1 | One-cycle request to start the generator |
| stop_i | input | 1 | One-cycle request to stop the generator |
| running_o | output | 1 | 1 while the generator is producing periods |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest states to reach from the ports lie at a period boundary that a pending request or a pending settings change has to wait for. Examples are a stop issued partway through a period and a settings write that lands while the old period still has hundreds of steps to run. The bench creates these cases by first locking onto a period start, found as an edge into the active level. It then issues the request a known number of cycles later, so the exact edge where the flag falls, or where the new duty first shows, can be predicted. The prescale-7 clamp and the slow-tick source give periods of thousands of cycles. These are measured edge to edge on the output, with the first, transitional period discarded.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int CMP_W = 8;   // threshold width, also the step counter width
  localparam int PS_W  = 3;   // prescale field width

  typedef struct packed {
    logic [CMP_W-1:0] thr;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_set_t;

  localparam pwm_set_t SET_RESET = '{thr: '0, pol: 1'b1, ps: '0};
endpackage

// File: rtl/bl_pwm_rst_sync.sv
module bl_pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow
  import bl_pwm_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int THR_LSB = 8,
  parameter int POL_BIT = 4,
  parameter int PS_MAX  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output pwm_set_t         pend_o
);
  pwm_set_t pend_q, pend_d;
  logic [PS_W-1:0] ps_raw;
  logic unused_bits;

  assign ps_raw      = wdata_i[PS_W-1:0];
  assign unused_bits = ^wdata_i;

  always_comb begin
    pend_d     = pend_q;
    pend_d.thr = wdata_i[THR_LSB +: CMP_W];
    pend_d.pol = wdata_i[POL_BIT];
    pend_d.ps  = (int'(ps_raw) > PS_MAX) ? PS_W'(PS_MAX) : ps_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_q <= SET_RESET;
    else if (we_i) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase
  import bl_pwm_pkg::*;
#(
  parameter int PS_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic [CMP_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int PRE_W = (PS_MAX > 0) ? PS_MAX : 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic [CMP_W-1:0] cnt_q, cnt_d;
  logic             step, upd;

  assign mask   = ~({PRE_W{1'b1}} << ps_i);
  assign step   = run_i && tick_i && (pre_q == mask);
  assign wrap_o = step && (cnt_q == {CMP_W{1'b1}});
  assign upd    = !run_i || tick_i;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (step) begin
      pre_d = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl
  import bl_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     tick_i,
  input  logic     wrap_i,
  input  pwm_set_t pend_i,
  output logic     run_o,
  output pwm_set_t act_o
);
  logic     req_q, req_d, run_q, run_d, load;
  pwm_set_t act_q;

  always_comb begin
    req_d = req_q;
    if (stop_i)       req_d = 1'b0;
    else if (start_i) req_d = 1'b1;
  end

  always_comb begin
    if (!run_q) run_d = req_q && tick_i;
    else        run_d = wrap_i ? req_q : 1'b1;
  end

  assign load = !run_q || wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      req_q <= req_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= SET_RESET;
    else if (load) act_q <= pend_i;
  end

  assign run_o = run_q;
  assign act_o = act_q;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int THR_LSB     = 8,
  parameter int POL_BIT     = 4,
  parameter int PS_MAX      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_sel_i,
  input  logic             slow_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             running_o,
  output logic             pwm_o
);
  logic             rst_n_s, tick, wrap, run, active;
  logic [CMP_W-1:0] cnt;
  pwm_set_t         pend_set, act_set;

  bl_pwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  bl_pwm_shadow #(.CFG_W(CFG_W), .THR_LSB(THR_LSB), .POL_BIT(POL_BIT),
                  .PS_MAX(PS_MAX)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .pend_o(pend_set));

  assign tick = clk_sel_i ? 1'b1 : slow_tick_i;

  bl_pwm_timebase #(.PS_MAX(PS_MAX)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(run), .tick_i(tick),
    .ps_i(act_set.ps), .cnt_o(cnt), .wrap_o(wrap));

  bl_pwm_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n_s), .start_i(start_i), .stop_i(stop_i),
    .tick_i(tick), .wrap_i(wrap), .pend_i(pend_set),
    .run_o(run), .act_o(act_set));

  assign active    = run && (cnt < act_set.thr);
  assign pwm_o     = act_set.pol ? active : !active;
  assign running_o = run;
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
#(
  parameter int PS_MAX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             run,
  input logic [CMP_W-1:0] cnt,
  input logic [CMP_W-1:0] act_thr,
  input logic             act_pol,
  input logic [PS_W-1:0]  act_ps,
  input logic             pwm
);
  assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tick));

  assert_fall_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(wrap));

  assert_idle_count_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt == '0));

  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm == !act_pol));

  assert_ps_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_ps) <= PS_MAX);

  assert_hold_midperiod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(act_thr) && $stable(act_pol) && $stable(act_ps)));

  assert_last_step_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == {CMP_W{1'b1}}) |-> (pwm == !act_pol));

  assert_stall_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

bind bl_pwm_top bl_pwm_chk #(.PS_MAX(PS_MAX)) u_chk (
  .clk(clk_i), .rst_n(rst_n_s), .tick(tick), .wrap(wrap), .run(run),
  .cnt(cnt), .act_thr(act_set.thr), .act_pol(act_set.pol),
  .act_ps(act_set.ps), .pwm(pwm_o));

// File: tb/tb_bl_pwm_top.sv
module tb_bl_pwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_ni, clk_sel, slow_tick, cfg_we, start, stop;
  logic [15:0] cfg_wdata;
  logic        running, pwm;

  int    n_checks = 0, n_errors = 0, cycles = 0, tdiv = 0;
  string phase = "R1";
  bit    model_on = 1'b0;

  // reference model state
  int m_req, m_run, m_pre, m_cnt;
  int m_pthr, m_ppol, m_pps, m_athr, m_apol, m_aps;

  bl_pwm_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(clk_sel), .slow_tick_i(slow_tick),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .start_i(start), .stop_i(stop),
    .running_o(running), .pwm_o(pwm));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_req = 0; m_run = 0; m_pre = 0; m_cnt = 0;
      m_pthr = 0; m_ppol = 1; m_pps = 0; m_athr = 0; m_apol = 1; m_aps = 0;
    end else begin
      int tk, per_step, stp, wrp, n_req, n_run, n_pre, n_cnt;
      bit ld;
      tk = clk_sel ? 1 : int'(slow_tick);
      per_step = 1 << m_aps;
      stp = (m_run != 0 && tk != 0 && m_pre == per_step - 1) ? 1 : 0;
      wrp = (stp != 0 && m_cnt == 255) ? 1 : 0;
      n_req = stop ? 0 : (start ? 1 : m_req);
      if (m_run == 0) begin
        n_run = (m_req != 0 && tk != 0) ? 1 : 0;
        n_pre = 0; n_cnt = 0; ld = 1;
      end else begin
        n_run = wrp ? m_req : 1;
        ld = (wrp != 0);
        n_pre = tk ? ((m_pre == per_step - 1) ? 0 : m_pre + 1) : m_pre;
        n_cnt = stp ? (m_cnt + 1) % 256 : m_cnt;
      end
      if (ld) begin m_athr = m_pthr; m_apol = m_ppol; m_aps = m_pps; end
      if (cfg_we) begin
        m_pthr = int'(cfg_wdata[15:8]);
        m_ppol = int'(cfg_wdata[4]);
        m_pps  = (cfg_wdata[2:0] == 3'd7) ? 6 : int'(cfg_wdata[2:0]);
      end
      m_req = n_req; m_run = n_run; m_pre = n_pre; m_cnt = n_cnt;
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (model_on) begin
      int act, e_pwm;
      act   = (m_run != 0 && m_cnt < m_athr) ? 1 : 0;
      e_pwm = (m_apol != 0) ? act : 1 - act;
      check(int'(running) == m_run, {phase, " running_o vs model"}, int'(running), m_run);
      check(int'(pwm) == e_pwm, {phase, " pwm_o vs model"}, int'(pwm), e_pwm);
    end
  end

  // slow tick source: one pulse every fourth cycle
  always @(negedge clk) begin
    tdiv++;
    slow_tick = ((tdiv % 4) == 3);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input int thr, input bit pol, input int ps);
    cfg_wdata = {8'(thr), 3'b000, pol, 1'b0, 3'(ps)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit p);
    start = s; stop = p;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  // cycles from one entry into level lv to the next, and time spent at lv
  task automatic measure(input logic lv, output int per, output int hi);
    logic prev;
    prev = pwm;
    do begin prev = pwm; @(negedge clk); end while (!(pwm == lv && prev != lv));
    per = 0; hi = 0;
    do begin
      if (pwm == lv) hi++;
      per++;
      prev = pwm;
      @(negedge clk);
    end while (!(pwm == lv && prev != lv));
  endtask

  task automatic meas_chk(input logic lv, input string req, input int e_per, input int e_hi);
    int per, hi;
    measure(lv, per, hi);              // first period may be transitional
    measure(lv, per, hi);
    check(per == e_per, {req, " period"}, per, e_per);
    check(hi == e_hi, {req, " active time"}, hi, e_hi);
  endtask

  initial begin
    int n, hits;
    rst_ni = 1'b0; clk_sel = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    start = 1'b0; stop = 1'b0; slow_tick = 1'b0;
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(5);
    model_on = 1'b1;

    // R1: reset state
    check(running == 1'b0, "R1 running after reset", int'(running), 0);
    check(pwm == 1'b0, "R1 pwm after reset", int'(pwm), 0);

    // R9: start timing with system clock selected
    phase = "R9";
    write_cfg(64, 1'b1, 0);
    pulse(1'b1, 1'b0);
    check(running == 1'b0, "R9 flag one edge after strobe", int'(running), 0);
    @(negedge clk);
    check(running == 1'b1, "R9 flag two edges after strobe", int'(running), 1);

    // R2 / R4: threshold 64, prescale 0
    phase = "R4";
    meas_chk(1'b1, "R4", 256, 64);

    // R8: change mid-period; old threshold still governs this period
    phase = "R8";
    write_cfg(128, 1'b1, 1);
    wait_cyc(100);
    check(pwm == 1'b0, "R8 old threshold kept mid-period", int'(pwm), 0);
    phase = "R2";
    meas_chk(1'b1, "R2", 512, 256);

    // R3: prescale 7 clamps to 6
    phase = "R3";
    write_cfg(1, 1'b1, 7);
    meas_chk(1'b1, "R3", 16384, 64);

    // R5: maximum threshold
    phase = "R5";
    write_cfg(255, 1'b1, 0);
    meas_chk(1'b1, "R5", 256, 255);

    // R6: inverted polarity, active level low
    phase = "R6";
    write_cfg(64, 1'b0, 0);
    meas_chk(1'b0, "R6", 256, 64);

    // R7: slow tick every fourth cycle
    phase = "R7";
    clk_sel = 1'b0;
    write_cfg(16, 1'b1, 0);
    meas_chk(1'b1, "R7", 1024, 64);
    clk_sel = 1'b1;

    // R4: threshold 0 never active
    phase = "R4";
    write_cfg(0, 1'b1, 0);
    wait_cyc(600);
    hits = 0;
    for (int i = 0; i < 512; i++) begin
      if (pwm) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R4 threshold zero active cycles", hits, 0);

    // R10: stop mid-period waits for the period end
    phase = "R10";
    write_cfg(64, 1'b1, 0);
    wait_cyc(600);
    begin
      int p, h;
      measure(1'b1, p, h);             // ends at count 0 of a period
    end
    wait_cyc(10);
    pulse(1'b0, 1'b1);
    n = 1;
    while (running && n < 2000) begin @(negedge clk); n++; end
    check(n == 246, "R10 edges from stop to flag fall", n, 246);
    check(pwm == 1'b0, "R10 output inactive after stop", int'(pwm), 0);

    // R11: idle level follows written polarity
    phase = "R11";
    write_cfg(64, 1'b0, 0);
    @(negedge clk);
    check(pwm == 1'b1, "R11 idle level inverted polarity", int'(pwm), 1);
    check(running == 1'b0, "R11 still stopped", int'(running), 0);

    // R12: simultaneous start and stop acts as stop
    phase = "R12";
    pulse(1'b1, 1'b1);
    wait_cyc(6);
    check(running == 1'b0, "R12 simultaneous strobes", int'(running), 0);
    check(pwm == 1'b1, "R12 output stays idle", int'(pwm), 1);

    model_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule